// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read side of a 16-bit NOR-style memory. It keeps a word array whose contents are computed from the address, and it has a 16-bit read configuration register. That register chooses between two read modes. In the asynchronous mode the output simply follows the address one clock later. In the synchronous burst mode an active-low address-valid strobe latches a start address. After a programmed number of clocks, words stream out one per clock.

In burst mode the register sets three things: the initial latency, the burst length (4, 8 or 16 words, or unbounded), and whether the address wraps inside the aligned burst window or runs on linearly. A write that carries an unsupported length code, or a latency above the supported maximum, is dropped as a whole. A new strobe during a burst discards that burst and starts the latency count again.

Top module: `burst_rd_seq`

## Requirements
- R1: While reset is high and after it falls, the register reads back 16'h800F, `dvalid` is 0 and `dout` is 0 until the first edge after reset.
- R2: A register write takes effect at the clock edge where `cfg_we` is high. Readback keeps bit 15 (mode), bits 13:11 (latency), bit 3 (no-wrap) and bits 2:0 (length code). Every other bit, bits 5:4 included, always reads 0.
- R3: A write is ignored and the register keeps its value when its length code is not one of 001, 010, 011 or 111, or when its latency code is above 4.
- R4: While bit 15 is 1, every edge loads `dout` with the word at the sampled `addr` and sets `dvalid` to 1. The strobe has no effect in this mode.
- R5: The word stored at address a is {a[7:0] XOR 8'hC3, a[7:0] + 8'h11}.
- R6: In burst mode with latency code N, a strobe sampled low at edge E makes the word at the start address valid after edge E+N, with `dvalid` low between those edges. Code 0 makes it valid after E itself.
- R7: With bit 3 = 1 and a finite length, successive words come from start, start+1, start+2 and so on, one per clock, with the address modulo 2^ADDR_W.
- R8: With bit 3 = 0 and a finite length L, the low log2(L) address bits count modulo L and the upper bits stay fixed. The burst keeps cycling until the next strobe.
- R9: With bit 3 = 1 and a finite length L, exactly L words are valid. `dvalid` then stays 0 until the next strobe.
- R10: Length code 111 gives an unbounded linear burst whatever the value of bit 3.
- R11: A strobe sampled low during a burst drops `dvalid` after that edge and restarts the sequence from the new address, with the full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr | input | ADDR_W | Read address |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 16 | Configuration write word |
| cfg_rdata | output | 16 | Configuration register readback |
| dout | output | 16 | Read data |
| dvalid | output | 1 | High when `dout` holds a valid word |

## Verification
A register write shows on readback right after its own edge. In asynchronous mode the word for an address is due one edge after that address is sampled. In burst mode the first word is due exactly N edges after the edge that samples the strobe, and each following word is due one edge later. The bench changes inputs one time unit after an edge and samples outputs at that same moment. It counts edges from the strobe edge and checks `dvalid` low during each latency gap. It then compares every later cycle against an address sequence it computes itself for the length, wrap and end-of-burst rules.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int unsigned WORD_W = 16;
    localparam logic [WORD_W-1:0] CFG_KEEP_MASK = 16'hB80F;
    localparam logic [WORD_W-1:0] CFG_RESET     = 16'h800F;

    typedef enum logic [2:0] {
        BLEN_4    = 3'b001,
        BLEN_8    = 3'b010,
        BLEN_16   = 3'b011,
        BLEN_CONT = 3'b111
    } blen_e;

    typedef struct packed {
        logic       async_mode;
        logic [2:0] lat;
        logic       no_wrap;
        logic [2:0] blen;
    } rcfg_t;

    typedef struct packed {
        logic       no_wrap;
        logic [2:0] blen;
    } shape_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DATA
    } bstate_e;

    function automatic rcfg_t unpack_cfg(input logic [WORD_W-1:0] w);
        rcfg_t c;
        c.async_mode = w[15];
        c.lat        = w[13:11];
        c.no_wrap    = w[3];
        c.blen       = w[2:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cfg(input rcfg_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[15]    = c.async_mode;
        w[13:11] = c.lat;
        w[3]     = c.no_wrap;
        w[2:0]   = c.blen;
        return w;
    endfunction

    function automatic logic len_code_ok(input logic [2:0] code);
        return (code == BLEN_4) || (code == BLEN_8) ||
               (code == BLEN_16) || (code == BLEN_CONT);
    endfunction

    function automatic logic [4:0] burst_words(input logic [2:0] code);
        case (code)
            BLEN_4:  return 5'd4;
            BLEN_8:  return 5'd8;
            BLEN_16: return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] word_at(input logic [WORD_W-1:0] a);
        return {a[7:0] ^ 8'hC3, a[7:0] + 8'h11};
    endfunction

endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
    import brs_pkg::*;
#(
    parameter int unsigned MAX_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output rcfg_t             cfg,
    output logic [WORD_W-1:0] rdata
);
    rcfg_t cfg_q;
    rcfg_t wr_cfg;
    logic  accept;

    always_comb begin
        wr_cfg = unpack_cfg(wdata);
        accept = len_code_ok(wr_cfg.blen) && (32'(wr_cfg.lat) <= MAX_LAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= unpack_cfg(CFG_RESET);
        end else if (we && accept) begin
            cfg_q <= wr_cfg;
        end
    end

    assign cfg   = cfg_q;
    assign rdata = pack_cfg(cfg_q);
endmodule

// File: rtl/brs_word_array.sv
module brs_word_array
    import brs_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        assign mem[i] = word_at(WORD_W'(i));
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/brs_burst_ctrl.sv
module brs_burst_ctrl
    import brs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MAX_LAT   = 4,
    parameter int unsigned MAX_BURST = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  rcfg_t             cfg,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] dout,
    output logic              dvalid
);
    localparam int unsigned LAT_W = $clog2(MAX_LAT + 1);
    localparam int unsigned NW_W  = $clog2(MAX_BURST + 1);

    bstate_e           st_q, st_d;
    logic [LAT_W-1:0]  cnt_q, cnt_d;
    logic [ADDR_W-1:0] cur_q, cur_d;
    logic [NW_W-1:0]   nw_q, nw_d;
    shape_t            shp_q, shp_d;
    logic              emit;
    logic [ADDR_W-1:0] sel;
    logic [WORD_W-1:0] dout_q;
    logic              dvalid_q;
    logic [NW_W-1:0]   len_w;
    logic              finite;

    function automatic logic [ADDR_W-1:0] step_addr(
        input logic [ADDR_W-1:0] cur,
        input shape_t            s
    );
        logic [ADDR_W-1:0] inc;
        logic [ADDR_W-1:0] msk;
        inc = cur + 1'b1;
        msk = ADDR_W'(burst_words(s.blen)) - 1'b1;
        if (s.no_wrap || (burst_words(s.blen) == 5'd0)) begin
            return inc;
        end
        return (cur & ~msk) | (inc & msk);
    endfunction

    always_comb begin
        len_w  = NW_W'(burst_words(shp_q.blen));
        finite = (len_w != '0);
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        cur_d = cur_q;
        nw_d  = nw_q;
        shp_d = shp_q;
        emit  = 1'b0;
        sel   = cur_q;
        if (cfg.async_mode) begin
            emit = 1'b1;
            sel  = addr;
            st_d = ST_IDLE;
        end else if (!adv_n) begin
            shp_d.no_wrap = cfg.no_wrap;
            shp_d.blen    = cfg.blen;
            cur_d         = addr;
            if (cfg.lat == 3'd0) begin
                emit = 1'b1;
                sel  = addr;
                st_d = ST_DATA;
                nw_d = NW_W'(1);
            end else begin
                st_d  = ST_WAIT;
                cnt_d = LAT_W'(cfg.lat);
            end
        end else begin
            case (st_q)
                ST_WAIT: begin
                    if (cnt_q == LAT_W'(1)) begin
                        emit = 1'b1;
                        sel  = cur_q;
                        st_d = ST_DATA;
                        nw_d = NW_W'(1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (finite && shp_q.no_wrap && (nw_q == len_w)) begin
                        st_d = ST_IDLE;
                    end else begin
                        emit = 1'b1;
                        sel  = step_addr(cur_q, shp_q);
                        if (nw_q < NW_W'(MAX_BURST)) begin
                            nw_d = nw_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (emit) begin
            cur_d = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cnt_q    <= '0;
            cur_q    <= '0;
            nw_q     <= '0;
            shp_q    <= '0;
            dout_q   <= '0;
            dvalid_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            cur_q    <= cur_d;
            nw_q     <= nw_d;
            shp_q    <= shp_d;
            dvalid_q <= emit;
            if (emit) begin
                dout_q <= rd_data;
            end
        end
    end

    assign rd_addr = sel;
    assign dout    = dout_q;
    assign dvalid  = dvalid_q;
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
    import brs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MAX_LAT   = 4,
    parameter int unsigned MAX_BURST = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    output logic [15:0]       dout,
    output logic              dvalid
);
    rcfg_t             cfg;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;

    brs_cfg_reg #(.MAX_LAT(MAX_LAT)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    brs_word_array #(.ADDR_W(ADDR_W)) u_arr (
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    brs_burst_ctrl #(
        .ADDR_W    (ADDR_W),
        .MAX_LAT   (MAX_LAT),
        .MAX_BURST (MAX_BURST)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .adv_n   (adv_n),
        .addr    (addr),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .dout    (dout),
        .dvalid  (dvalid)
    );
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cfg_we,
    input logic [15:0]       cfg_wdata,
    input logic [15:0]       cfg_rdata,
    input logic [15:0]       dout,
    input logic              dvalid
);
    logic bad_len;
    assign bad_len = !brs_pkg::len_code_ok(cfg_wdata[2:0]);

    assert_reset_value_R1: assert property (@(posedge clk)
        rst |=> (cfg_rdata == brs_pkg::CFG_RESET));

    assert_bad_write_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (bad_len || (cfg_wdata[13:11] > 3'd4))) |=> $stable(cfg_rdata));

    assert_async_valid_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[15] |=> dvalid);

    assert_async_data_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[15] |=> (dout == brs_pkg::word_at(16'($past(addr)))));

    assert_restart_gap_R11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[15] && !adv_n && (cfg_rdata[13:11] != 3'd0)) |=> !dvalid);
endmodule

bind burst_rd_seq brs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_n     (adv_n),
    .addr      (addr),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .dout      (dout),
    .dvalid    (dvalid)
);

// File: tb/sim_burst_rd_seq.sv
`timescale 1ns/1ps
module sim_burst_rd_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_n = 1'b1;
    logic [7:0]  addr = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [15:0] dout;
    logic        dvalid;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_cfg = 16'h800F;

    always #2.5 clk = ~clk;

    burst_rd_seq u0 (
        .clk(clk), .rst(rst), .adv_n(adv_n), .addr(addr),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dout(dout), .dvalid(dvalid)
    );

    // {configuration word, start address}
    localparam logic [23:0] VEC [7] = '{
        {16'h1009, 8'h2E},  // no wrap, 4 words, latency 2
        {16'h1802, 8'h45},  // wrap, 8 words, latency 3
        {16'h0803, 8'hFC},  // wrap, 16 words, latency 1
        {16'h200F, 8'hFE},  // continuous, latency 4
        {16'h000B, 8'h70},  // no wrap, 16 words, latency 0
        {16'h1007, 8'h13},  // continuous with wrap bit clear, latency 2
        {16'h180A, 8'hFA}   // no wrap, 8 words, latency 3
    };

    function automatic int len_of(input logic [2:0] c);
        if (c == 3'b001) return 4;
        if (c == 3'b010) return 8;
        if (c == 3'b011) return 16;
        return 0;
    endfunction

    function automatic logic [15:0] exp_word(input logic [7:0] a);
        logic [7:0] lo;
        lo = a + 8'h11;
        return {a ^ 8'hC3, lo};
    endfunction

    function automatic logic [7:0] exp_addr(input logic [7:0] base, input int k,
                                            input logic [2:0] c, input logic nw);
        int L;
        logic [7:0] lin;
        logic [7:0] m;
        L   = len_of(c);
        lin = base + 8'(k);
        if (L == 0 || nw) return lin;
        m = 8'(L - 1);
        return (base & ~m) | (lin & m);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_cfg(input logic [15:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        step();
        cfg_we = 1'b0;
        if (len_of(w[2:0]) != 0 || w[2:0] == 3'b111) begin
            if (w[13:11] <= 3'd4) model_cfg = w & 16'hB80F;
        end
        chk("R2/R3 readback", cfg_rdata, model_cfg);
    endtask

    task automatic run_burst(input logic [15:0] w, input logic [7:0] a);
        int n;
        int L;
        int k;
        string tag;
        wr_cfg(w);
        addr  = a;
        adv_n = 1'b0;
        step();
        adv_n = 1'b1;
        n = int'(w[13:11]);
        L = len_of(w[2:0]);
        for (int c = 0; c < n + 20; c++) begin
            if (c > 0) step();
            if (c < n) begin
                chk("R6 latency gap", {15'd0, dvalid}, 16'd0);
            end else begin
                k = c - n;
                if (L != 0 && w[3] && k >= L) begin
                    chk("R9 burst ended", {15'd0, dvalid}, 16'd0);
                end else begin
                    if (L == 0) tag = "R10 continuous";
                    else if (w[3]) tag = "R7 linear";
                    else tag = "R8 wrap";
                    if (k == 0) tag = "R6 first word";
                    chk(tag, {15'd0, dvalid}, 16'd1);
                    chk(tag, dout, exp_word(exp_addr(a, k, w[2:0], w[3])));
                end
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        step();
        // R1: values held in reset
        chk("R1 cfg", cfg_rdata, 16'h800F);
        chk("R1 dvalid", {15'd0, dvalid}, 16'd0);
        chk("R1 dout", dout, 16'd0);
        rst = 1'b0;

        // R4: asynchronous mode after reset, strobe has no effect
        addr  = 8'h5A;
        adv_n = 1'b0;
        step();
        chk("R4 async valid", {15'd0, dvalid}, 16'd1);
        chk("R4/R5 async data", dout, exp_word(8'h5A));
        addr = 8'hA7;
        step();
        adv_n = 1'b1;
        chk("R4/R5 async data", dout, exp_word(8'hA7));

        // R2: non-modelled bits read 0
        wr_cfg(16'h1039);
        wr_cfg(16'h47F1);
        // R3: bad length code and latency above 4 are dropped
        wr_cfg(16'h1005);
        chk("R3 bad length kept", cfg_rdata, 16'h0001);
        wr_cfg(16'h2801);
        chk("R3 bad latency kept", cfg_rdata, 16'h0001);
        wr_cfg(16'h3807);
        chk("R3 latency 7 kept", cfg_rdata, 16'h0001);

        // table walk: R6..R10
        for (int i = 0; i < 7; i++) begin
            run_burst(VEC[i][23:8], VEC[i][7:0]);
        end

        // R11: restart in the middle of a burst
        wr_cfg(16'h1007);
        addr  = 8'h10;
        adv_n = 1'b0;
        step();
        adv_n = 1'b1;
        step();
        step();
        chk("R11 before restart", dout, exp_word(8'h10));
        addr  = 8'h80;
        adv_n = 1'b0;
        step();
        adv_n = 1'b1;
        chk("R11 valid dropped", {15'd0, dvalid}, 16'd0);
        step();
        chk("R11 latency again", {15'd0, dvalid}, 16'd0);
        step();
        chk("R11 new start valid", {15'd0, dvalid}, 16'd1);
        chk("R11 new start data", dout, exp_word(8'h80));

        // back to async mode
        wr_cfg(16'h800F);
        addr = 8'h33;
        step();
        chk("R4 async again", dout, exp_word(8'h33));
        chk("R4 async valid again", {15'd0, dvalid}, 16'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule